// File: doc/BRIEF.md
# Software Trap Entry Controller

This block performs the state-saving part of a software trap in a pipelined processor. When the core raises a trap request with a 5-bit vector and the address of the trap instruction, the block commits the whole exception entry on a single clock edge. It saves the return address and the current status word into one of two save-register banks. It writes an exception code into one half of a cause register and sets status flags. It then redirects fetch to the handler entry that belongs to the vector, and it raises a one-cycle flush pulse.

The choice of bank follows the exception-pending flag of the status word. If no exception is being handled, the first-level bank and the low half of the cause register take the state. If an exception is already in progress, the second-level bank and the high half of the cause register are used instead. The block owns the status word. The core can load it through a write port, for example when a handler returns, and a trap in the same cycle takes precedence over that load.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, the status word equals the PSW_RESET parameter (0 by default). All four save registers and the cause register are 0, `flushPulse` is 0 and `redirectPc` is 0.
- R2: `flushPulse` is 1 in exactly the cycle after each cycle in which `trapReq` is sampled high, and 0 otherwise.
- R3: With status bit 14 (exception pending) at 0 when the trap is taken, `lvl1Pc` becomes `trapPc + INSN_BYTES` and `lvl1Psw` becomes the status word before the trap. `lvl2Pc` and `lvl2Psw` are unchanged.
- R4: With status bit 14 at 1 when the trap is taken, `lvl2Pc` becomes `trapPc + INSN_BYTES` and `lvl2Psw` becomes the status word before the trap. `lvl1Pc` and `lvl1Psw` are unchanged.
- R5: The exception code CODE_BASE + vector is written to `causeReg[15:0]` when bit 14 was 0, and to `causeReg[31:16]` when bit 14 was 1. The other half keeps its value.
- R6: A trap always sets status bit 12 (interrupt disable). It also sets bit 14 when bit 14 was 0, or bit 15 (fatal-level pending) when bit 14 was 1. All other status bits are kept.
- R7: After a trap, `redirectPc` is HANDLER_BASE + LO_OFFSET for vectors 0 to 15, and HANDLER_BASE + HI_OFFSET for vectors 16 to 31.
- R8: When `trapReq` is low, `pswWrEn` loads `pswWrData` into the status word. When both are high in the same cycle, the write data is ignored and the trap update applies.
- R9: In a cycle with neither `trapReq` nor `pswWrEn`, the status word, the save registers, the cause register and `redirectPc` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap instruction request, one entry per cycle high |
| trapVec | input | 5 | Trap vector 0 to 31 |
| trapPc | input | 32 | Address of the trap instruction |
| pswWrEn | input | 1 | Status word load strobe |
| pswWrData | input | 32 | Status word load data |
| psw | output | 32 | Current status word |
| lvl1Pc | output | 32 | First-level saved return address |
| lvl1Psw | output | 32 | First-level saved status word |
| lvl2Pc | output | 32 | Second-level saved return address |
| lvl2Psw | output | 32 | Second-level saved status word |
| causeReg | output | 32 | Second-level code [31:16], first-level code [15:0] |
| redirectPc | output | 32 | Handler fetch address |
| flushPulse | output | 1 | One-cycle pipeline flush |

## Verification
The bound checker watches every cycle for the flush timing, the bank selection from the pending flag, the return address written, the flag update, the handler address and the stability of all state on idle cycles. It also checks that the bank not chosen is left untouched. Only the bench scenarios show the full exception code in each cause half across all 32 vectors and the saved status value after arbitrary loads. The sweep also covers chained entries, where a trap arriving while pending escalates to the second level, and the precedence of a trap over a same-cycle status load.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef struct packed {
    logic take;     // a trap is committed this edge
    logic toLvl2;   // save into the second-level bank
    logic toLvl1;   // save into the first-level bank
    logic pswLoad;  // status load from the core
  } trapStrobes_t;
endpackage

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
  import trap_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trapReq,
  input  logic         pswWrEn,
  input  logic         pendingFlag,
  output trapStrobes_t strb,
  output logic         flushPulse
);
  always_comb begin
    strb.take    = trapReq;
    strb.toLvl2  = trapReq & pendingFlag;
    strb.toLvl1  = trapReq & ~pendingFlag;
    strb.pswLoad = pswWrEn & ~trapReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flushPulse <= 1'b0;
    else       flushPulse <= trapReq;
  end
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          VEC_W        = 5,
  parameter int          CODE_W       = 16,
  parameter int          INSN_BYTES   = 4,
  parameter int          ID_BIT       = 12,
  parameter int          EP_BIT       = 14,
  parameter int          NP_BIT       = 15,
  parameter logic [31:0] PSW_RESET    = 32'h0,
  parameter logic [31:0] HANDLER_BASE = 32'hFFFF_FF00,
  parameter logic [31:0] LO_OFFSET    = 32'h0000_00A0,
  parameter logic [31:0] HI_OFFSET    = 32'h0000_00B0,
  parameter logic [15:0] CODE_BASE    = 16'hFFA0
) (
  input  logic                clk,
  input  logic                rstN,
  input  trapStrobes_t        strb,
  input  logic [VEC_W-1:0]    trapVec,
  input  logic [ADDR_W-1:0]   trapPc,
  input  logic [ADDR_W-1:0]   pswWrData,
  output logic                pendingFlag,
  output logic [ADDR_W-1:0]   psw,
  output logic [ADDR_W-1:0]   lvl1Pc,
  output logic [ADDR_W-1:0]   lvl1Psw,
  output logic [ADDR_W-1:0]   lvl2Pc,
  output logic [ADDR_W-1:0]   lvl2Psw,
  output logic [2*CODE_W-1:0] causeReg,
  output logic [ADDR_W-1:0]   redirectPc
);
  localparam logic [ADDR_W-1:0] ID_MASK = ADDR_W'(1) << ID_BIT;
  localparam logic [ADDR_W-1:0] EP_MASK = ADDR_W'(1) << EP_BIT;
  localparam logic [ADDR_W-1:0] NP_MASK = ADDR_W'(1) << NP_BIT;

  logic [ADDR_W-1:0] returnPc, handlerPc, pswTrapped;
  logic [CODE_W-1:0] excCode;

  assign pendingFlag = psw[EP_BIT];

  always_comb begin
    returnPc   = trapPc + ADDR_W'(INSN_BYTES);
    excCode    = CODE_W'(CODE_BASE) + CODE_W'(trapVec);
    handlerPc  = ADDR_W'(HANDLER_BASE) +
                 (trapVec[VEC_W-1] ? ADDR_W'(HI_OFFSET) : ADDR_W'(LO_OFFSET));
    pswTrapped = psw | ID_MASK | (strb.toLvl2 ? NP_MASK : EP_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psw        <= ADDR_W'(PSW_RESET);
      lvl1Pc     <= '0;
      lvl1Psw    <= '0;
      lvl2Pc     <= '0;
      lvl2Psw    <= '0;
      causeReg   <= '0;
      redirectPc <= '0;
    end else begin
      if (strb.take) begin
        psw        <= pswTrapped;
        redirectPc <= handlerPc;
      end else if (strb.pswLoad) begin
        psw <= pswWrData;
      end
      if (strb.toLvl1) begin
        lvl1Pc             <= returnPc;
        lvl1Psw            <= psw;
        causeReg[CODE_W-1:0] <= excCode;
      end
      if (strb.toLvl2) begin
        lvl2Pc                    <= returnPc;
        lvl2Psw                   <= psw;
        causeReg[2*CODE_W-1:CODE_W] <= excCode;
      end
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          VEC_W        = 5,
  parameter int          CODE_W       = 16,
  parameter int          INSN_BYTES   = 4,
  parameter int          ID_BIT       = 12,
  parameter int          EP_BIT       = 14,
  parameter int          NP_BIT       = 15,
  parameter logic [31:0] PSW_RESET    = 32'h0,
  parameter logic [31:0] HANDLER_BASE = 32'hFFFF_FF00,
  parameter logic [31:0] LO_OFFSET    = 32'h0000_00A0,
  parameter logic [31:0] HI_OFFSET    = 32'h0000_00B0,
  parameter logic [15:0] CODE_BASE    = 16'hFFA0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trapReq,
  input  logic [VEC_W-1:0]    trapVec,
  input  logic [ADDR_W-1:0]   trapPc,
  input  logic                pswWrEn,
  input  logic [ADDR_W-1:0]   pswWrData,
  output logic [ADDR_W-1:0]   psw,
  output logic [ADDR_W-1:0]   lvl1Pc,
  output logic [ADDR_W-1:0]   lvl1Psw,
  output logic [ADDR_W-1:0]   lvl2Pc,
  output logic [ADDR_W-1:0]   lvl2Psw,
  output logic [2*CODE_W-1:0] causeReg,
  output logic [ADDR_W-1:0]   redirectPc,
  output logic                flushPulse
);
  trapStrobes_t strb;
  logic         pendingFlag;

  trap_entry_ctl u_ctl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .pswWrEn(pswWrEn),
    .pendingFlag(pendingFlag), .strb(strb), .flushPulse(flushPulse)
  );

  trap_entry_dp #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .CODE_W(CODE_W), .INSN_BYTES(INSN_BYTES),
    .ID_BIT(ID_BIT), .EP_BIT(EP_BIT), .NP_BIT(NP_BIT), .PSW_RESET(PSW_RESET),
    .HANDLER_BASE(HANDLER_BASE), .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET),
    .CODE_BASE(CODE_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .trapVec(trapVec), .trapPc(trapPc),
    .pswWrData(pswWrData), .pendingFlag(pendingFlag), .psw(psw),
    .lvl1Pc(lvl1Pc), .lvl1Psw(lvl1Psw), .lvl2Pc(lvl2Pc), .lvl2Psw(lvl2Psw),
    .causeReg(causeReg), .redirectPc(redirectPc)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int          ADDR_W       = 32,
  parameter int          VEC_W        = 5,
  parameter int          CODE_W       = 16,
  parameter int          INSN_BYTES   = 4,
  parameter int          ID_BIT       = 12,
  parameter int          EP_BIT       = 14,
  parameter int          NP_BIT       = 15,
  parameter logic [31:0] HANDLER_BASE = 32'hFFFF_FF00,
  parameter logic [31:0] LO_OFFSET    = 32'h0000_00A0,
  parameter logic [31:0] HI_OFFSET    = 32'h0000_00B0
) (
  input logic                clk,
  input logic                rstN,
  input logic                trapReq,
  input logic [VEC_W-1:0]    trapVec,
  input logic [ADDR_W-1:0]   trapPc,
  input logic                pswWrEn,
  input logic [ADDR_W-1:0]   psw,
  input logic [ADDR_W-1:0]   lvl1Pc,
  input logic [ADDR_W-1:0]   lvl1Psw,
  input logic [ADDR_W-1:0]   lvl2Pc,
  input logic [ADDR_W-1:0]   lvl2Psw,
  input logic [2*CODE_W-1:0] causeReg,
  input logic [ADDR_W-1:0]   redirectPc,
  input logic                flushPulse
);
  // R2
  flush_after_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> flushPulse);
  // R2
  no_flush_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> !flushPulse);
  // R3
  lvl1_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !psw[EP_BIT]) |=>
      (lvl1Pc == $past(trapPc) + ADDR_W'(INSN_BYTES)) && $stable(lvl2Pc) && $stable(lvl2Psw));
  // R4
  lvl2_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && psw[EP_BIT]) |=>
      (lvl2Pc == $past(trapPc) + ADDR_W'(INSN_BYTES)) && $stable(lvl1Pc) && $stable(lvl1Psw));
  // R6
  flags_lvl1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !psw[EP_BIT]) |=> psw[ID_BIT] && psw[EP_BIT]);
  // R6
  flags_lvl2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && psw[EP_BIT]) |=> psw[ID_BIT] && psw[NP_BIT] && psw[EP_BIT]);
  // R7
  handler_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> redirectPc == ADDR_W'(HANDLER_BASE) +
      ($past(trapVec[VEC_W-1]) ? ADDR_W'(HI_OFFSET) : ADDR_W'(LO_OFFSET)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && !pswWrEn) |=> $stable(psw) && $stable(lvl1Pc) && $stable(lvl1Psw) &&
      $stable(lvl2Pc) && $stable(lvl2Psw) && $stable(causeReg) && $stable(redirectPc));
endmodule

bind trap_entry_ctrl trap_entry_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .CODE_W(CODE_W), .INSN_BYTES(INSN_BYTES),
  .ID_BIT(ID_BIT), .EP_BIT(EP_BIT), .NP_BIT(NP_BIT),
  .HANDLER_BASE(HANDLER_BASE), .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET)
) u_chk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapVec(trapVec), .trapPc(trapPc),
  .pswWrEn(pswWrEn), .psw(psw), .lvl1Pc(lvl1Pc), .lvl1Psw(lvl1Psw),
  .lvl2Pc(lvl2Pc), .lvl2Psw(lvl2Psw), .causeReg(causeReg),
  .redirectPc(redirectPc), .flushPulse(flushPulse)
);

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;
  localparam logic [31:0] HBASE = 32'hFFFF_FF00;
  localparam logic [31:0] LOOFF = 32'h0000_00A0;
  localparam logic [31:0] HIOFF = 32'h0000_00B0;
  localparam logic [15:0] CBASE = 16'hFFA0;

  logic        clk = 0, rstN = 0, trapReq = 0, pswWrEn = 0;
  logic [4:0]  trapVec = 0;
  logic [31:0] trapPc = 0, pswWrData = 0;
  logic [31:0] psw, lvl1Pc, lvl1Psw, lvl2Pc, lvl2Psw, causeReg, redirectPc;
  logic        flushPulse;
  int checks = 0, errors = 0;
  logic [31:0] mPsw = 0, mL1Pc = 0, mL1Psw = 0, mL2Pc = 0, mL2Psw = 0, mCause = 0, mRedir = 0;

  always #2 clk = ~clk;

  trap_entry_ctrl u_trap_entry_ctrl (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapVec(trapVec), .trapPc(trapPc),
    .pswWrEn(pswWrEn), .pswWrData(pswWrData), .psw(psw), .lvl1Pc(lvl1Pc),
    .lvl1Psw(lvl1Psw), .lvl2Pc(lvl2Pc), .lvl2Psw(lvl2Psw), .causeReg(causeReg),
    .redirectPc(redirectPc), .flushPulse(flushPulse)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic expFlush);
    check({tag, " R2 flush"}, {31'b0, flushPulse}, {31'b0, expFlush});
    check({tag, " R6/R8 psw"}, psw, mPsw);
    check({tag, " R3 lvl1Pc"}, lvl1Pc, mL1Pc);
    check({tag, " R3 lvl1Psw"}, lvl1Psw, mL1Psw);
    check({tag, " R4 lvl2Pc"}, lvl2Pc, mL2Pc);
    check({tag, " R4 lvl2Psw"}, lvl2Psw, mL2Psw);
    check({tag, " R5 cause"}, causeReg, mCause);
    check({tag, " R7 redirect"}, redirectPc, mRedir);
  endtask

  // model of one trap entry from the requirements
  task automatic modelTrap(input logic [4:0] v, input logic [31:0] pc);
    logic [15:0] code = CBASE + 16'(v);
    if (!mPsw[14]) begin
      mL1Pc = pc + 4; mL1Psw = mPsw; mCause[15:0] = code;
      mPsw = mPsw | 32'h0000_5000;
    end else begin
      mL2Pc = pc + 4; mL2Psw = mPsw; mCause[31:16] = code;
      mPsw = mPsw | 32'h0000_9000;
    end
    mRedir = HBASE + (v >= 5'd16 ? HIOFF : LOOFF);
  endtask

  task automatic doTrap(input logic [4:0] v, input logic [31:0] pc, input logic alsoWrite);
    trapReq = 1; trapVec = v; trapPc = pc;
    pswWrEn = alsoWrite; pswWrData = 32'hA5A5_A5A5;
    modelTrap(v, pc);
    @(negedge clk);
    trapReq = 0; pswWrEn = 0;
    checkAll(alsoWrite ? "R8 collide" : "trap", 1'b1);
  endtask

  task automatic pswWrite(input logic [31:0] d);
    pswWrEn = 1; pswWrData = d; mPsw = d;
    @(negedge clk);
    pswWrEn = 0;
    check("R8 psw load", psw, d);
  endtask

  task automatic idle();
    trapPc = 32'hDEAD_0000; trapVec = 5'd31;
    @(negedge clk);
    checkAll("R9 idle", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1 reset", 1'b0);
    rstN = 1;
    @(negedge clk);
    idle();
    for (int v = 0; v < 32; v++) begin
      pswWrite((32'(v) * 32'h0101_0301) & ~32'h0000_D000);
      doTrap(5'(v), 32'h0001_0000 + 32'(v) * 32'h44, 1'b0);   // first level
      idle();
      doTrap(5'(31 - v), 32'h0200_0000 + 32'(v) * 32'h8, 1'b0); // second level
      idle();
    end
    // R8: trap beats a same-cycle status load, both levels
    pswWrite(32'h0000_0003);
    doTrap(5'd7, 32'h0000_1230, 1'b1);
    doTrap(5'd20, 32'h0000_4560, 1'b1);
    idle();
    // R1: reset returns everything to its initial value
    rstN = 0;
    @(negedge clk);
    mPsw = 0; mL1Pc = 0; mL1Psw = 0; mL2Pc = 0; mL2Psw = 0; mCause = 0; mRedir = 0;
    checkAll("R1 re-reset", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule